// File: doc/BRIEF.md
# Reloadable Transfer Length Counter

This block holds the byte count for a host adapter's DMA transfers. Software programs the count one byte at a time. Each byte goes into a holding copy that is not yet active. The active (live) count is read back through the same byte addresses. The live count takes the programmed value only when the command decoder reports a command issued with its DMA flag set. Because of this, software can stage the next count while the current one is still running.

The DMA engine consumes the live count through a decrement port. The decrement saturates at zero and marks the step to zero with a one-cycle terminal-count pulse. An end-of-transfer strobe forces the live count to zero and raises a count-zero status bit. A live value of zero means a length of 0x10000. The block also reports the amount that will actually move, which is the smaller of that effective length and the remaining data size. Until software first writes the top count byte, reads of its address return a fixed identification byte.

Top module: `tc_xfer_counter`

## Requirements
- R1: After reset the low and middle addresses (0 and 1) read 0x00, address 2 reads CHIP_ID (default 0xA2), `eff_len_o` is 0x10000, and `tc_o`, `tc_zero_o` and `dma_mode_o` are 0.
- R2: A register write to count byte k (address 0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16) changes only that byte's holding copy. The live count and its read-back stay unchanged.
- R3: A write to any count address clears `tc_zero_o` on the next cycle.
- R4: `cmd_wr_i` with `cmd_dma_i` high loads all three live bytes from the holding copies on the next edge and sets `dma_mode_o`.
- R5: `cmd_wr_i` with `cmd_dma_i` low leaves the live count unchanged and clears `dma_mode_o`.
- R6: `eff_len_o` equals the live count {byte2, byte1, byte0}, except that a live count of zero gives 0x10000.
- R7: Address 2 reads CHIP_ID until it has been written once since the last hard or soft reset. After that it returns live byte 2.
- R8: `done_i` forces the live count to zero and sets `tc_zero_o` on the next cycle. It has priority over reload and decrement.
- R9: `xfer_len_o` is the smaller of `eff_len_o` and `remain_i`.
- R10: `dec_i` subtracts `dec_cnt_i` from the live count and saturates at zero.
- R11: A decrement that takes a nonzero live count to zero raises `tc_o` for exactly the next cycle and sets `tc_zero_o`. A decrement of a count that is already zero raises no pulse.
- R12: `soft_rst_i` returns the holding copies, live count, written-once flag and all status outputs to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| soft_rst_i | input | 1 | Synchronous soft reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Count byte address (0 low, 1 middle, 2 high) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (live byte or CHIP_ID) |
| cmd_wr_i | input | 1 | Command issued pulse |
| cmd_dma_i | input | 1 | DMA flag of the issued command |
| done_i | input | 1 | Transfer finished strobe |
| dec_i | input | 1 | Decrement request |
| dec_cnt_i | input | 24 | Bytes to subtract |
| remain_i | input | 24 | Remaining data size |
| eff_len_o | output | 24 | Effective length (zero count gives 0x10000) |
| xfer_len_o | output | 24 | Length actually moved |
| tc_o | output | 1 | One-cycle terminal-count pulse |
| tc_zero_o | output | 1 | Count-zero status |
| dma_mode_o | output | 1 | Last command carried the DMA flag |

## Verification
The count path is tested with three kinds of values:
- A mixed three-byte value exposes byte-lane swaps on reload and read-back.
- A value whose only nonzero byte is the low byte, drained exactly to zero, separates an exact terminal step from a saturated one.
- A zero count checks the 0x10000 substitution in both the effective and the moved length.

Each count write is followed by a read-back before any command is issued, which shows the write did not reach the live count. A command without the DMA flag then shows that reload depends on that flag. Oversized and undersized remaining sizes are used to select each side of the minimum.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    LIVE_HOLD,
    LIVE_CLEAR,
    LIVE_LOAD,
    LIVE_DEC
  } live_op_e;
endpackage

// File: rtl/tc_shadow.sv
`timescale 1ns/1ps
module tc_shadow import tc_pkg::*; #(
  parameter int unsigned BYTES  = 3,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      soft_rst_i,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [BYTE_W-1:0]         wdata_i,
  output logic [BYTE_W*BYTES-1:0]   shadow_o,
  output logic                      hi_written_o
);
  localparam int unsigned HI_IDX = BYTES - 1;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  byte_q <= '0;
      else if (soft_rst_i)                          byte_q <= '0;
      else if (wr_i && (32'(addr_i) == 32'(b)))     byte_q <= wdata_i;
    end
    assign shadow_o[b*BYTE_W +: BYTE_W] = byte_q;
  end

  // sticky until hard or soft reset
  logic written_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    written_q <= 1'b0;
    else if (soft_rst_i)                            written_q <= 1'b0;
    else if (wr_i && (32'(addr_i) == HI_IDX))       written_q <= 1'b1;
  end
  assign hi_written_o = written_q;
endmodule

// File: rtl/tc_live.sv
`timescale 1ns/1ps
module tc_live import tc_pkg::*; #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  live_op_e         op_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] dec_cnt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_hit_o,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, dec_res;
  logic             tc_q;

  always_comb begin
    dec_res    = (cnt_q > dec_cnt_i) ? (cnt_q - dec_cnt_i) : '0;
    zero_hit_o = (op_i == LIVE_DEC) && (cnt_q != '0) && (dec_res == '0);
    unique case (op_i)
      LIVE_CLEAR: cnt_d = '0;
      LIVE_LOAD:  cnt_d = load_i;
      LIVE_DEC:   cnt_d = dec_res;
      default:    cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tc_q  <= zero_hit_o;
    end
  end

  assign cnt_o = cnt_q;
  assign tc_o  = tc_q;
endmodule

// File: rtl/tc_len.sv
`timescale 1ns/1ps
module tc_len #(
  parameter int unsigned CNT_W         = 24,
  parameter int unsigned ZERO_LEN_LOG2 = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] remain_i,
  output logic [CNT_W-1:0] eff_len_o,
  output logic [CNT_W-1:0] xfer_len_o
);
  localparam logic [CNT_W-1:0] ZERO_LEN = CNT_W'(1) << ZERO_LEN_LOG2;

  assign eff_len_o  = (cnt_i == '0) ? ZERO_LEN : cnt_i;
  assign xfer_len_o = (remain_i < eff_len_o) ? remain_i : eff_len_o;
endmodule

// File: rtl/tc_xfer_counter.sv
`timescale 1ns/1ps
module tc_xfer_counter import tc_pkg::*; #(
  parameter int unsigned BYTES         = 3,
  parameter int unsigned ADDR_W        = 2,
  parameter logic [7:0]  CHIP_ID       = 8'hA2,
  parameter int unsigned ZERO_LEN_LOG2 = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    soft_rst_i,
  input  logic                    reg_wr_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [BYTE_W-1:0]       reg_wdata_i,
  output logic [BYTE_W-1:0]       reg_rdata_o,
  input  logic                    cmd_wr_i,
  input  logic                    cmd_dma_i,
  input  logic                    done_i,
  input  logic                    dec_i,
  input  logic [BYTE_W*BYTES-1:0] dec_cnt_i,
  input  logic [BYTE_W*BYTES-1:0] remain_i,
  output logic [BYTE_W*BYTES-1:0] eff_len_o,
  output logic [BYTE_W*BYTES-1:0] xfer_len_o,
  output logic                    tc_o,
  output logic                    tc_zero_o,
  output logic                    dma_mode_o
);
  localparam int unsigned CNT_W  = BYTE_W * BYTES;
  localparam int unsigned HI_IDX = BYTES - 1;

  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] live_q;
  logic             hi_written;
  logic             zero_hit;
  logic             cnt_wr;
  logic             tc_zero_q;
  logic             dma_mode_q;
  live_op_e         live_op;

  assign cnt_wr = reg_wr_i && (32'(reg_addr_i) < BYTES);

  tc_shadow #(.BYTES(BYTES), .ADDR_W(ADDR_W)) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .shadow_o    (shadow_q),
    .hi_written_o(hi_written)
  );

  // clear > reload > decrement
  always_comb begin
    if (soft_rst_i || done_i)        live_op = LIVE_CLEAR;
    else if (cmd_wr_i && cmd_dma_i)  live_op = LIVE_LOAD;
    else if (dec_i)                  live_op = LIVE_DEC;
    else                             live_op = LIVE_HOLD;
  end

  tc_live #(.CNT_W(CNT_W)) u_live (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (live_op),
    .load_i    (shadow_q),
    .dec_cnt_i (dec_cnt_i),
    .cnt_o     (live_q),
    .zero_hit_o(zero_hit),
    .tc_o      (tc_o)
  );

  tc_len #(.CNT_W(CNT_W), .ZERO_LEN_LOG2(ZERO_LEN_LOG2)) u_len (
    .cnt_i     (live_q),
    .remain_i  (remain_i),
    .eff_len_o (eff_len_o),
    .xfer_len_o(xfer_len_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tc_zero_q <= 1'b0;
    else if (soft_rst_i)         tc_zero_q <= 1'b0;
    else if (done_i || zero_hit) tc_zero_q <= 1'b1;
    else if (cnt_wr)             tc_zero_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         dma_mode_q <= 1'b0;
    else if (soft_rst_i) dma_mode_q <= 1'b0;
    else if (cmd_wr_i)   dma_mode_q <= cmd_dma_i;
  end

  assign tc_zero_o  = tc_zero_q;
  assign dma_mode_o = dma_mode_q;

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < int'(BYTES); b++) begin
      if (32'(reg_addr_i) == 32'(b)) reg_rdata_o = live_q[b*BYTE_W +: BYTE_W];
    end
    if ((32'(reg_addr_i) == HI_IDX) && !hi_written) reg_rdata_o = CHIP_ID;
  end
endmodule

// File: rtl/tc_xfer_counter_chk.sv
`timescale 1ns/1ps
module tc_xfer_counter_chk #(
  parameter int unsigned BYTES         = 3,
  parameter int unsigned ADDR_W        = 2,
  parameter logic [7:0]  CHIP_ID       = 8'hA2,
  parameter int unsigned ZERO_LEN_LOG2 = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 soft_rst_i,
  input logic                 reg_wr_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [7:0]           reg_rdata_o,
  input logic                 cmd_wr_i,
  input logic                 cmd_dma_i,
  input logic                 done_i,
  input logic                 dec_i,
  input logic [8*BYTES-1:0]   dec_cnt_i,
  input logic [8*BYTES-1:0]   remain_i,
  input logic [8*BYTES-1:0]   eff_len_o,
  input logic [8*BYTES-1:0]   xfer_len_o,
  input logic                 tc_o,
  input logic                 tc_zero_o,
  input logic                 dma_mode_o,
  input logic [8*BYTES-1:0]   live_q,
  input logic [8*BYTES-1:0]   shadow_q,
  input logic                 hi_written
);
  localparam int unsigned CNT_W = 8 * BYTES;
  localparam logic [CNT_W-1:0] ZERO_LEN = CNT_W'(1) << ZERO_LEN_LOG2;
  localparam int unsigned HI_IDX = BYTES - 1;

  logic quiet;
  assign quiet = !soft_rst_i && !done_i && !dec_i && !cmd_wr_i;

  AST_WR_SHADOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && quiet |=> $stable(live_q)); // R2
  AST_WR_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && (32'(reg_addr_i) < BYTES) && quiet |=> !tc_zero_o); // R3
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_dma_i && !done_i && !soft_rst_i |=> (live_q == $past(shadow_q)) && dma_mode_o); // R4
  AST_NODMA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && !cmd_dma_i && !done_i && !dec_i && !soft_rst_i |=> $stable(live_q) && !dma_mode_o); // R5
  AST_EFF_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_len_o == ((live_q == '0) ? ZERO_LEN : live_q)); // R6
  AST_CHIP_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_written && (32'(reg_addr_i) == HI_IDX) |-> reg_rdata_o == CHIP_ID); // R7
  AST_WRITTEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_written && !soft_rst_i |=> hi_written); // R7
  AST_DONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !soft_rst_i |=> (live_q == '0) && tc_zero_o); // R8
  AST_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_len_o <= eff_len_o) && (xfer_len_o <= remain_i) &&
    ((xfer_len_o == eff_len_o) || (xfer_len_o == remain_i))); // R9
  AST_DEC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !cmd_wr_i && !done_i && !soft_rst_i && (dec_cnt_i >= live_q) |=> live_q == '0); // R10
  AST_TC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o); // R11
  AST_TC_ZERO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> tc_zero_o || $past(soft_rst_i) || $past(reg_wr_i)); // R11
  AST_SOFT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (live_q == '0) && (shadow_q == '0) && !hi_written && !tc_zero_o && !dma_mode_o && !tc_o); // R12
endmodule

bind tc_xfer_counter tc_xfer_counter_chk #(
  .BYTES(BYTES), .ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID), .ZERO_LEN_LOG2(ZERO_LEN_LOG2)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .reg_wr_i(reg_wr_i),
  .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o), .cmd_wr_i(cmd_wr_i),
  .cmd_dma_i(cmd_dma_i), .done_i(done_i), .dec_i(dec_i), .dec_cnt_i(dec_cnt_i),
  .remain_i(remain_i), .eff_len_o(eff_len_o), .xfer_len_o(xfer_len_o), .tc_o(tc_o),
  .tc_zero_o(tc_zero_o), .dma_mode_o(dma_mode_o), .live_q(live_q),
  .shadow_q(shadow_q), .hi_written(hi_written)
);

// File: tb/tc_xfer_counter_bench.sv
`timescale 1ns/1ps
module tc_xfer_counter_bench;
  localparam int SEL_RD = 0, SEL_EFF = 1, SEL_XFER = 2, SEL_TC = 3, SEL_TCZ = 4, SEL_DMA = 5;
  localparam logic [7:0] ID = 8'hA2;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_i = 1'b0, reg_wr_i = 1'b0, cmd_wr_i = 1'b0, cmd_dma_i = 1'b0;
  logic        done_i = 1'b0, dec_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [23:0] dec_cnt_i = '0, remain_i = 24'hFFFFFF;
  logic [7:0]  reg_rdata_o;
  logic [23:0] eff_len_o, xfer_len_o;
  logic        tc_o, tc_zero_o, dma_mode_o;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tc_xfer_counter u_tc_xfer_counter (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .cmd_wr_i(cmd_wr_i), .cmd_dma_i(cmd_dma_i), .done_i(done_i), .dec_i(dec_i),
    .dec_cnt_i(dec_cnt_i), .remain_i(remain_i), .eff_len_o(eff_len_o),
    .xfer_len_o(xfer_len_o), .tc_o(tc_o), .tc_zero_o(tc_zero_o), .dma_mode_o(dma_mode_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
    soft_rst_i = 0; reg_wr_i = 0; cmd_wr_i = 0; cmd_dma_i = 0; done_i = 0; dec_i = 0;
  endtask

  task automatic expect_v(int sel, logic [31:0] exp, string tag);
    item_t it;
    it.due = cyc; it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr_cnt(logic [1:0] a, logic [7:0] d);
    step(); reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
  endtask

  task automatic cmd(logic dma);
    step(); cmd_wr_i = 1; cmd_dma_i = dma;
  endtask

  task automatic dec(logic [23:0] n);
    step(); dec_i = 1; dec_cnt_i = n;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    step(); reg_addr_i = a; expect_v(SEL_RD, 32'(exp), tag);
  endtask

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.sel)
          SEL_RD:   act = 32'(reg_rdata_o);
          SEL_EFF:  act = 32'(eff_len_o);
          SEL_XFER: act = 32'(xfer_len_o);
          SEL_TC:   act = 32'(tc_o);
          SEL_TCZ:  act = 32'(tc_zero_o);
          default:  act = 32'(dma_mode_o);
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    // R1 reset state
    rd(2'd0, 8'h00, "R1 low byte");
    rd(2'd1, 8'h00, "R1 mid byte");
    rd(2'd2, ID, "R1 R7 high reads id");
    expect_v(SEL_EFF, 32'h10000, "R1 R6 zero length");
    expect_v(SEL_TCZ, 0, "R1 tc_zero");
    expect_v(SEL_DMA, 0, "R1 dma_mode");
    expect_v(SEL_TC, 0, "R1 tc");
    // R8 done raises tc_zero
    step(); done_i = 1;
    step(); expect_v(SEL_TCZ, 1, "R8 tc_zero set");
    // R2 R3 writes reach only the holding copies
    wr_cnt(2'd0, 8'h34);
    step(); expect_v(SEL_TCZ, 0, "R3 write clears tc_zero");
    wr_cnt(2'd1, 8'h12);
    wr_cnt(2'd2, 8'h05);
    rd(2'd0, 8'h00, "R2 live low unchanged");
    rd(2'd2, 8'h00, "R7 high reads live after write");
    expect_v(SEL_EFF, 32'h10000, "R2 eff unchanged");
    // R4 reload
    cmd(1'b1);
    step(); expect_v(SEL_EFF, 32'h051234, "R4 R6 reload");
    expect_v(SEL_DMA, 1, "R4 dma_mode");
    rd(2'd0, 8'h34, "R4 low byte");
    rd(2'd1, 8'h12, "R4 mid byte");
    rd(2'd2, 8'h05, "R4 high byte");
    // R9 minimum
    step(); remain_i = 24'h000100; expect_v(SEL_XFER, 32'h100, "R9 remain smaller");
    step(); remain_i = 24'h060000; expect_v(SEL_XFER, 32'h051234, "R9 length smaller");
    // R5 no-DMA command
    wr_cnt(2'd0, 8'h77);
    cmd(1'b0);
    step(); expect_v(SEL_DMA, 0, "R5 dma_mode cleared");
    expect_v(SEL_EFF, 32'h051234, "R5 live unchanged");
    // R10 R11 decrement and saturation
    dec(24'h001234);
    step(); expect_v(SEL_EFF, 32'h050000, "R10 partial decrement");
    expect_v(SEL_TC, 0, "R11 no pulse while nonzero");
    dec(24'h060000);
    step(); expect_v(SEL_TC, 1, "R11 pulse on saturate");
    expect_v(SEL_EFF, 32'h10000, "R10 saturated to zero");
    expect_v(SEL_TCZ, 1, "R11 tc_zero set");
    step(); expect_v(SEL_TC, 0, "R11 pulse one cycle");
    // exact drain
    wr_cnt(2'd0, 8'h10);
    wr_cnt(2'd1, 8'h00);
    wr_cnt(2'd2, 8'h00);
    cmd(1'b1);
    step(); expect_v(SEL_EFF, 32'h10, "R4 reload small");
    dec(24'h000010);
    step(); expect_v(SEL_TC, 1, "R11 pulse on exact zero");
    dec(24'h000005);
    step(); expect_v(SEL_TC, 0, "R11 no pulse from zero");
    expect_v(SEL_EFF, 32'h10000, "R10 stays zero");
    // R8 done after reload
    cmd(1'b1);
    step(); expect_v(SEL_EFF, 32'h10, "R4 reload again");
    step(); done_i = 1;
    step(); expect_v(SEL_EFF, 32'h10000, "R8 live forced zero");
    expect_v(SEL_TCZ, 1, "R8 tc_zero");
    rd(2'd0, 8'h00, "R8 low byte zero");
    step(); remain_i = 24'h020000; expect_v(SEL_XFER, 32'h10000, "R9 R6 zero count length");
    step(); remain_i = 24'h000000; expect_v(SEL_XFER, 32'h0, "R9 zero remain");
    // R12 soft reset
    wr_cnt(2'd2, 8'h09);
    cmd(1'b1);
    step(); soft_rst_i = 1;
    step(); expect_v(SEL_TCZ, 0, "R12 tc_zero");
    expect_v(SEL_DMA, 0, "R12 dma_mode");
    expect_v(SEL_EFF, 32'h10000, "R12 live cleared");
    rd(2'd2, ID, "R12 R7 id returns");
    cmd(1'b1);
    step(); expect_v(SEL_EFF, 32'h10000, "R12 holding copies cleared");
    repeat (3) step();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule